// File: doc/BRIEF.md
# Banked Memory Window Decoder

This block turns each access of an 8-bit processor with a 16-bit address bus into chip selects and a physical RAM address. The upper half of the address space (0x8000 to 0xFFFF) always goes to a fixed RAM area. The lower half (0x0000 to 0x7FFF) is a 32 KB window. A 3-bit bank code chooses what the window shows: the first RAM bank, a 16 KB video RAM, one of five more 32 KB RAM banks, or a 16 KB ROM.

Each extra RAM bank answers only when the installed RAM is large enough to hold it. The video RAM and the ROM decode only the low 14 address bits, so each appears twice inside the window. The ROM never takes a write. A read that nothing answers is flagged so that the bus shows all ones.

The installed-size setting is captured while reset is high. The bank code is captured when an access begins and holds until the strobes drop. All outputs are registered and appear one clock after the edge that samples the access.

Top module: `bank_window_decoder`

## Requirements
- R1: An access with address bit 15 set drives `fixed_sel_n` low and sets `phys_addr` = 0x08000 + address[14:0]. This holds whatever the bank code is, and such a write asserts `mem_we`.
- R2: An answered access below 0x8000 with bank code c drives only `bank_sel_n[c]` low. The code values are 0 for the first RAM bank, 1 for video RAM, 2 to 6 for extra RAM banks 2 to 6, and 7 for ROM.
- R3: At most one of the nine selects is low in any cycle. With neither `cpu_rd` nor `cpu_wr` high, every select is high, and `mem_we` and `no_resp` are low.
- R4: Codes 1 and 7 set `phys_addr` = address[13:0] with all upper bits zero, so addresses that differ only in bit 14 reach the same location.
- R5: A write with code 7 drives no select low and keeps `mem_we` low.
- R6: Code 0 sets `phys_addr` = address[14:0]. Code c in 2 to 6 sets `phys_addr` = c*0x8000 + address[14:0], which gives bases 0x10000 to 0x30000.
- R7: `size_cfg` encodes installed RAM as 0=64, 1=96, 2=128, 3=160, 4=192 and 5=224 KB, with 6 and 7 treated as 224 KB. Bank c (2..6) answers only when the encoded size is at least c-1.
- R8: A read that no target answers raises `no_resp`, and `fill_data` becomes 0xFF. In every other cycle `fill_data` is 0x00.
- R9: `size_cfg` is sampled only while `rst` is high. Changes after reset have no effect on decoding.
- R10: The bank code is captured on the first cycle that a strobe is high. Changing the code while a strobe stays high does not change the decode. The next access uses the new code.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. During and right after reset, every select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples size_cfg |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| bank_code | input | 3 | Window bank selection |
| size_cfg | input | 3 | Installed RAM size code |
| bank_sel_n | output | 8 | Active-low select, one per bank code |
| fixed_sel_n | output | 1 | Active-low select of the fixed upper RAM |
| phys_addr | output | 18 | Physical address for the selected target; zero when none |
| mem_we | output | 1 | Write enable to the selected writable target |
| no_resp | output | 1 | Read answered by nothing |
| fill_data | output | 8 | Value for the undriven read bus |

## Verification
The bench sweeps all eight size codes and covers each gating threshold on both sides. A decoder with an off-by-one threshold would answer from RAM that is not fitted, or stay silent on a bank that is. ROM writes are aimed at both mirror halves, where a design that lets writes through would assert `mem_we` and corrupt the ROM. A bank code is changed in the middle of a held read: a design that re-decodes would jump to the other select. The size input is changed after reset, which exposes a decoder that tracks it live. Addresses differing only in bit 14 check that video RAM and ROM drop that bit, while bit 14 still picks apart the two halves of each RAM bank.

// File: rtl/bank_win_pkg.sv
package bank_win_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int SIZE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    BK_RAM_FIRST = 3'd0,
    BK_VIDEO     = 3'd1,
    BK_RAM_B2    = 3'd2,
    BK_RAM_B3    = 3'd3,
    BK_RAM_B4    = 3'd4,
    BK_RAM_B5    = 3'd5,
    BK_RAM_B6    = 3'd6,
    BK_ROM       = 3'd7
  } bank_code_e;

  // largest meaningful size code (224 KB); higher codes clamp to it
  localparam logic [SIZE_W-1:0] SIZE_MAX = 3'd5;

  function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] s);
    return (s > SIZE_MAX) ? SIZE_MAX : s;
  endfunction
endpackage

// File: rtl/bank_size_gate.sv
module bank_size_gate
  import bank_win_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SIZE_W-1:0]    size_cfg,
  output logic [NUM_CODES-1:0] avail
);
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) size_q <= clamp_size(size_cfg);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_avail
      if (g >= int'(BK_RAM_B2) && g <= int'(BK_RAM_B6)) begin : g_extra
        assign avail[g] = (size_q >= SIZE_W'(g - 1));
      end else begin : g_fixed
        assign avail[g] = 1'b1;
      end
    end
  endgenerate

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(avail)); // R9
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_win_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PHYS_W   = 18,
  parameter int MIRROR_W = 14
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [CODE_W-1:0]    code,
  input  logic [NUM_CODES-1:0] avail,
  output logic [NUM_CODES-1:0] sel_n,
  output logic                 fixed_n,
  output logic [PHYS_W-1:0]    phys,
  output logic                 we,
  output logic                 open
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] off;
  logic             active;
  logic             hit;

  assign off    = addr[OFF_W-1:0];
  assign active = rd | wr;

  always_comb begin
    sel_n   = '1;
    fixed_n = 1'b1;
    phys    = '0;
    we      = 1'b0;
    hit     = 1'b0;
    if (active) begin
      if (addr[ADDR_W-1]) begin
        fixed_n = 1'b0;
        hit     = 1'b1;
        phys    = PHYS_W'(1) << OFF_W | PHYS_W'(off);
        we      = wr;
      end else begin
        unique case (bank_code_e'(code))
          BK_VIDEO: begin
            hit  = 1'b1;
            phys = PHYS_W'(off[MIRROR_W-1:0]);
            we   = wr;
          end
          BK_ROM: begin
            hit  = ~wr;
            phys = hit ? PHYS_W'(off[MIRROR_W-1:0]) : '0;
          end
          default: begin
            hit  = avail[code];
            phys = hit ? (PHYS_W'(code) << OFF_W | PHYS_W'(off)) : '0;
            we   = hit & wr;
          end
        endcase
        sel_n[code] = ~hit;
      end
    end
    open = rd & ~hit;
  end
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bank_win_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PHYS_W   = 18,
  parameter int DATA_W   = 8,
  parameter int MIRROR_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [CODE_W-1:0]    bank_code,
  input  logic [SIZE_W-1:0]    size_cfg,
  output logic [NUM_CODES-1:0] bank_sel_n,
  output logic                 fixed_sel_n,
  output logic [PHYS_W-1:0]    phys_addr,
  output logic                 mem_we,
  output logic                 no_resp,
  output logic [DATA_W-1:0]    fill_data
);
  logic [NUM_CODES-1:0] avail;
  logic                 active, active_q;
  logic [CODE_W-1:0]    code_lat, code_eff;

  logic [NUM_CODES-1:0] d_sel_n;
  logic                 d_fixed_n, d_we, d_open;
  logic [PHYS_W-1:0]    d_phys;

  bank_size_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .size_cfg (size_cfg),
    .avail    (avail)
  );

  assign active   = cpu_rd | cpu_wr;
  assign code_eff = (active && !active_q) ? bank_code : code_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      code_lat <= '0;
    end else begin
      active_q <= active;
      code_lat <= code_eff;
    end
  end

  bank_decode #(
    .ADDR_W   (ADDR_W),
    .PHYS_W   (PHYS_W),
    .MIRROR_W (MIRROR_W)
  ) u_dec (
    .addr    (cpu_addr),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .code    (code_eff),
    .avail   (avail),
    .sel_n   (d_sel_n),
    .fixed_n (d_fixed_n),
    .phys    (d_phys),
    .we      (d_we),
    .open    (d_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel_n  <= '1;
      fixed_sel_n <= 1'b1;
      phys_addr   <= '0;
      mem_we      <= 1'b0;
      no_resp     <= 1'b0;
      fill_data   <= '0;
    end else begin
      bank_sel_n  <= d_sel_n;
      fixed_sel_n <= d_fixed_n;
      phys_addr   <= d_phys;
      mem_we      <= d_we;
      no_resp     <= d_open;
      fill_data   <= d_open ? '1 : '0;
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~{fixed_sel_n, bank_sel_n}) <= 1); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd || cpu_wr) |=> (&bank_sel_n && fixed_sel_n && !mem_we && !no_resp)); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) && cpu_addr[ADDR_W-1] |=> !fixed_sel_n); // R1
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bank_sel_n[BK_ROM] |-> !mem_we); // R5
  AST_OPEN_SILENT: assert property (@(posedge clk) disable iff (rst)
    no_resp |-> (&bank_sel_n && fixed_sel_n && &fill_data)); // R8
endmodule

// File: tb/bank_window_decoder_bench.sv
module bank_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [2:0]  bank_code = '0;
  logic [2:0]  size_cfg = '0;
  logic [7:0]  bank_sel_n;
  logic        fixed_sel_n;
  logic [17:0] phys_addr;
  logic        mem_we, no_resp;
  logic [7:0]  fill_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_window_decoder u_bank_window_decoder (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .bank_code(bank_code), .size_cfg(size_cfg), .bank_sel_n(bank_sel_n),
    .fixed_sel_n(fixed_sel_n), .phys_addr(phys_addr), .mem_we(mem_we),
    .no_resp(no_resp), .fill_data(fill_data)
  );

  // packed expectation: {fixed_n, sel_n[7:0], phys[17:0], we, open, fill[7:0]}
  function automatic logic [36:0] model(input logic [15:0] a, input logic r,
                                        input logic w, input logic [2:0] c,
                                        input logic [2:0] cfg);
    logic [7:0] s = 8'hFF; logic f = 1'b1; logic [17:0] p = '0;
    logic e = 1'b0; logic o; logic [2:0] sz = (cfg > 3'd5) ? 3'd5 : cfg;
    if (r || w) begin
      if (a[15]) begin f = 1'b0; p = 18'h08000 | 18'(a[14:0]); e = w; end
      else if (c == 3'd0) begin s[0] = 1'b0; p = 18'(a[14:0]); e = w; end
      else if (c == 3'd1) begin s[1] = 1'b0; p = 18'(a[13:0]); e = w; end
      else if (c == 3'd7) begin
        if (!w) begin s[7] = 1'b0; p = 18'(a[13:0]); end
      end else if (sz >= c - 3'd1) begin
        s[c] = 1'b0; p = {c, a[14:0]}; e = w;
      end
    end
    o = r && f && (&s);
    return {f, s, p, e, o, o ? 8'hFF : 8'h00};
  endfunction

  function automatic logic [36:0] observed();
    return {fixed_sel_n, bank_sel_n, phys_addr, mem_we, no_resp, fill_data};
  endfunction

  task automatic check(input string req, input logic [36:0] exp);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, observed(), exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] cfg);
    @(negedge clk); rst = 1'b1; size_cfg = cfg; cpu_rd = 0; cpu_wr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // one access cycle then one idle cycle; checks the access (R11 timing)
  task automatic access(input string req, input logic [15:0] a, input logic r,
                        input logic w, input logic [2:0] c, input logic [2:0] cfg);
    @(negedge clk); cpu_addr = a; cpu_rd = r; cpu_wr = w; bank_code = c;
    @(posedge clk); #2;
    check(req, model(a, r, w, c, cfg));
    @(negedge clk); cpu_rd = 0; cpu_wr = 0;
    @(posedge clk); #2;
    check("R3 idle", model(a, 0, 0, c, cfg));
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(3'd0);
    @(posedge clk); #2;
    check("R11 reset state", model(16'h0, 0, 0, 0, 0));

    // R1 upper half regardless of bank
    access("R1 upper read", 16'hC123, 1, 0, 3'd6, 3'd0);
    access("R1 upper write", 16'h8001, 0, 1, 3'd7, 3'd0);
    // R2/R6 first bank, video
    access("R6 bank0 write", 16'h7ABC, 0, 1, 3'd0, 3'd0);
    access("R4 video mirror low", 16'h0123, 1, 0, 3'd1, 3'd0);
    access("R4 video mirror high", 16'h4123, 0, 1, 3'd1, 3'd0);
    // R5 ROM
    access("R4 rom read mirror", 16'h5555, 1, 0, 3'd7, 3'd0);
    access("R5 rom write low", 16'h1234, 0, 1, 3'd7, 3'd0);
    access("R5 rom write high", 16'h5234, 0, 1, 3'd7, 3'd0);
    // R7/R8 bank 2 absent at 64 KB
    access("R8 absent bank read", 16'h0042, 1, 0, 3'd2, 3'd0);
    access("R7 absent bank write", 16'h0042, 0, 1, 3'd2, 3'd0);

    // R9: change cfg after reset, still 64 KB
    @(negedge clk); size_cfg = 3'd5;
    access("R9 cfg ignored after reset", 16'h2000, 1, 0, 3'd6, 3'd0);

    // R7 thresholds for every size code
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(3'(cfg));
      for (int c = 2; c <= 6; c++)
        access("R7 threshold", 16'h6000 | 16'(c), 1, 0, 3'(c), 3'(cfg));
      for (int n = 0; n < 40; n++) begin
        logic [15:0] a = 16'($urandom);
        logic w = 1'($urandom);
        access("R2 R6 random", a, ~w, w, 3'($urandom), 3'(cfg));
      end
    end

    // R10: bank code changed in mid-access
    do_reset(3'd5);
    @(negedge clk); cpu_addr = 16'h1111; cpu_rd = 1; bank_code = 3'd2;
    @(posedge clk); #2; check("R10 first cycle", model(16'h1111, 1, 0, 3'd2, 3'd5));
    @(negedge clk); bank_code = 3'd3;
    @(posedge clk); #2; check("R10 held decode", model(16'h1111, 1, 0, 3'd2, 3'd5));
    @(negedge clk); cpu_rd = 0;
    @(posedge clk);
    @(negedge clk); cpu_rd = 1;
    @(posedge clk); #2; check("R10 next access", model(16'h1111, 1, 0, 3'd3, 3'd5));
    @(negedge clk); cpu_rd = 0;
    @(posedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule